// File: doc/BRIEF.md
# Programmable Address Window Decoder

The decoder holds five software-programmable address windows and resolves each incoming 32-bit CPU address against them in the same cycle. A window is described by four 32-bit registers: a control word that holds an enable bit and a 4-bit target identifier, a size mask, a base and a remap address. Size and base count in 64 KiB units. For every address the block reports whether a window claimed it, which window did, the target identifier of that window, and the address rewritten into the target's space.

Software programs the windows through a small valid/ready register port. The port always accepts a request in the cycle it is presented. Read data comes back one cycle later. A configuration write changes the decode result from the next cycle on. Overlapping windows are allowed, and the lowest-numbered window always wins. A size mask that is not a solid run of ones from bit 0 switches its window off, so a malformed mask cannot claim a fragmented address set.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads zero, every window is disabled, `hit_o` is low and `tgt_o` is 4'hF.
- R2: Window w occupies register byte offsets w*16 to w*16+15. Slot 0 is control (bit 0 enable, bits [7:4] target). Slot 4 is size (bits [15:0]). Slot 8 is base (bits [15:0]). Slot 12 is remap (bits [31:16]). Reads return only these stored bits, and all other bits read zero. Address bits [1:0] are ignored.
- R3: Register offsets at 0x50 and above read zero. Writes to them change no register and no decode result.
- R4: A window whose enable bit is 0 never produces a hit.
- R5: An enabled window with size mask S and base B matches when (addr[31:16] & ~S) == (B & ~S). Base bits that lie under S have no effect, and the window length is (S+1)*64 KiB.
- R6: On a hit, `tgt_o` carries the matched window's target field unchanged. Code 0 selects DRAM and code 2 selects PCIe.
- R7: When several enabled windows match, `hit_o` is high and `win_o` and `tgt_o` come from the lowest-numbered one.
- R8: With no match, `hit_o` is 0, `tgt_o` is 4'hF, `win_o` is 0 and `xaddr_o` equals `addr_i`.
- R9: On a hit, `xaddr_o[31:16]` is (remap[31:16] & ~S) | (addr[31:16] & S), and `xaddr_o[15:0]` equals `addr_i[15:0]`.
- R10: A window whose size mask is not of the form 2^k-1 (for example 0x0005) is treated as disabled.
- R11: A register write accepted on a clock edge affects decode right after that edge. A read accepted on an edge presents `reg_rvalid_o` high and its data after that same edge. `reg_ready_o` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register request valid |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_ready_o | output | 1 | Request accepted (always high) |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the read |
| reg_rdata_o | output | 32 | Read data |
| addr_i | input | 32 | CPU address to decode |
| hit_o | output | 1 | Some enabled window matched |
| tgt_o | output | 4 | Target identifier, 4'hF on a miss |
| win_o | output | 3 | Index of the matching window |
| xaddr_o | output | 32 | Translated address |

## Verification
Window 2 is placed entirely inside window 0, so a decoder with the wrong priority would report window 2 and a different translation. The tests then disable window 0 in a single write and decode in the very next cycle, which exposes a one-cycle configuration lag. A non-contiguous mask of 0x0005 checks that such a window is rejected rather than claiming a scattered address set. Windows with masks of zero and 0x3FFF check both edges of a window, so an off-by-one in the length or a masked base bit leaking into the compare shows up as a wrong hit or miss. Readback tests with all-ones data and reads of unused offsets catch field bits stored at the wrong position and stray data returned from the holes in the map.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ADDR_W  = 32;
  localparam int GRAN    = 16;
  localparam int FIELD_W = ADDR_W - GRAN;
  localparam int TGT_W   = 4;

  localparam logic [TGT_W-1:0] TGT_DRAM = 4'h0;
  localparam logic [TGT_W-1:0] TGT_PCIE = 4'h2;
  localparam logic [TGT_W-1:0] TGT_NONE = 4'hF;

  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_SIZE  = 2'd1,
    SLOT_BASE  = 2'd2,
    SLOT_REMAP = 2'd3
  } slot_e;

  typedef struct packed {
    logic               en;
    logic [TGT_W-1:0]   tgt;
    logic [FIELD_W-1:0] size;
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] remap;
  } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int REG_AW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              reg_ready_o,
  output logic              reg_rvalid_o,
  output logic [31:0]       reg_rdata_o,
  output win_cfg_t          cfg_o [NUM_WIN]
);
  localparam int WSEL_W = REG_AW - 4;

  logic [WSEL_W-1:0] wsel;
  slot_e             slot;
  logic              sel_ok, wr_en, rd_en;
  logic [31:0]       rd_word;
  logic [1:0]        addr_unused;
  logic [31:0]       wdata_unused;

  assign wsel         = reg_addr_i[REG_AW-1:4];
  assign slot         = slot_e'(reg_addr_i[3:2]);
  assign addr_unused  = reg_addr_i[1:0];
  assign wdata_unused = reg_wdata_i;
  assign sel_ok       = (32'(wsel) < NUM_WIN);
  assign wr_en        = reg_valid_i & reg_write_i & sel_ok;
  assign rd_en        = reg_valid_i & ~reg_write_i;
  assign reg_ready_o  = 1'b1;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    win_cfg_t q;
    logic     me;
    assign me = wr_en && (wsel == WSEL_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (me) begin
        unique case (slot)
          SLOT_CTRL: begin
            q.en  <= reg_wdata_i[0];
            q.tgt <= reg_wdata_i[7:4];
          end
          SLOT_SIZE:  q.size  <= reg_wdata_i[FIELD_W-1:0];
          SLOT_BASE:  q.base  <= reg_wdata_i[FIELD_W-1:0];
          SLOT_REMAP: q.remap <= reg_wdata_i[31:GRAN];
          default: ;
        endcase
      end
    end
    assign cfg_o[w] = q;

    AST_CTRL_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_valid_i && reg_write_i && reg_addr_i[REG_AW-1:2] == (REG_AW-2)'(w*4))
      |=> (cfg_o[w].en == $past(reg_wdata_i[0]) && cfg_o[w].tgt == $past(reg_wdata_i[7:4]))); // R2
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sel_ok && wsel == WSEL_W'(w)) begin
        unique case (slot)
          SLOT_CTRL:  rd_word = {{(32-TGT_W-4){1'b0}}, cfg_o[w].tgt, 3'b000, cfg_o[w].en};
          SLOT_SIZE:  rd_word = {{(32-FIELD_W){1'b0}}, cfg_o[w].size};
          SLOT_BASE:  rd_word = {{(32-FIELD_W){1'b0}}, cfg_o[w].base};
          SLOT_REMAP: rd_word = {cfg_o[w].remap, {GRAN{1'b0}}};
          default:    rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rvalid_o <= 1'b0;
      reg_rdata_o  <= '0;
    end else begin
      reg_rvalid_o <= rd_en;
      reg_rdata_o  <= rd_en ? rd_word : '0;
    end
  end

  AST_HOLE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !reg_write_i && !sel_ok) |=> (reg_rdata_o == '0)); // R3
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
(
  input  win_cfg_t           cfg_i,
  input  logic [FIELD_W-1:0] addr_hi_i,
  output logic               match_o,
  output logic [FIELD_W-1:0] xlat_hi_o
);
  logic size_ok;

  // a legal mask plus one has no bit in common with the mask
  assign size_ok   = ((cfg_i.size & (cfg_i.size + FIELD_W'(1))) == '0);
  assign match_o   = cfg_i.en & size_ok &
                     ((addr_hi_i & ~cfg_i.size) == (cfg_i.base & ~cfg_i.size));
  assign xlat_hi_o = (cfg_i.remap & ~cfg_i.size) | (addr_hi_i & cfg_i.size);
endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_WIN-1:0] match_i,
  input  logic [TGT_W-1:0]   tgt_i  [NUM_WIN],
  input  logic [FIELD_W-1:0] xlat_i [NUM_WIN],
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [TGT_W-1:0]   tgt_o,
  output logic [FIELD_W-1:0] xlat_hi_o
);
  always_comb begin
    hit_o     = 1'b0;
    idx_o     = '0;
    tgt_o     = TGT_NONE;
    xlat_hi_o = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match_i[w]) begin
        hit_o     = 1'b1;
        idx_o     = IDX_W'(w);
        tgt_o     = tgt_i[w];
        xlat_hi_o = xlat_i[w];
      end
    end
  end

  logic [NUM_WIN-1:0] below;
  always_comb
    for (int w = 0; w < NUM_WIN; w++) below[w] = (32'(idx_o) > w);

  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_i & below) == '0 && match_i[idx_o])); // R7
  AST_MISS_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (match_i == '0 && tgt_o == TGT_NONE)); // R8
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int REG_AW  = 8,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              reg_ready_o,
  output logic              reg_rvalid_o,
  output logic [31:0]       reg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [IDX_W-1:0]  win_o,
  output logic [ADDR_W-1:0] xaddr_o
);
  win_cfg_t           cfg    [NUM_WIN];
  logic [NUM_WIN-1:0] match;
  logic [TGT_W-1:0]   tgt    [NUM_WIN];
  logic [FIELD_W-1:0] xlat   [NUM_WIN];
  logic [FIELD_W-1:0] xlat_hi;

  awd_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i,
    .reg_ready_o, .reg_rvalid_o, .reg_rdata_o, .cfg_o(cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    awd_win_match u_match (
      .cfg_i(cfg[w]), .addr_hi_i(addr_i[ADDR_W-1:GRAN]),
      .match_o(match[w]), .xlat_hi_o(xlat[w])
    );
    assign tgt[w] = cfg[w].tgt;
  end

  awd_prio_sel #(.NUM_WIN(NUM_WIN)) u_prio (
    .clk_i, .rst_ni, .match_i(match), .tgt_i(tgt), .xlat_i(xlat),
    .hit_o, .idx_o(win_o), .tgt_o, .xlat_hi_o(xlat_hi)
  );

  assign xaddr_o = hit_o ? {xlat_hi, addr_i[GRAN-1:0]} : addr_i;

  AST_HIT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> cfg[win_o].en); // R4
  AST_HIT_MASK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((cfg[win_o].size & (cfg[win_o].size + FIELD_W'(1))) == '0)); // R10
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xaddr_o[GRAN-1:0] == addr_i[GRAN-1:0]); // R9
  AST_MISS_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (xaddr_o == addr_i && win_o == '0)); // R8
endmodule

// File: tb/addr_window_decoder_tb.sv
`timescale 1ns/1ps
module addr_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rv = 1'b0, rw = 1'b0;
  logic [7:0]  ra = '0;
  logic [31:0] rwd = '0;
  logic        rrdy, rrv;
  logic [31:0] rrd;
  logic [31:0] addr = '0;
  logic        hit;
  logic [3:0]  tgt;
  logic [2:0]  win;
  logic [31:0] xaddr;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  addr_window_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(rv), .reg_write_i(rw),
    .reg_addr_i(ra), .reg_wdata_i(rwd), .reg_ready_o(rrdy), .reg_rvalid_o(rrv),
    .reg_rdata_o(rrd), .addr_i(addr), .hit_o(hit), .tgt_o(tgt), .win_o(win),
    .xaddr_o(xaddr)
  );

  // {addr, hit, tgt, win, xaddr}
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {32'h1234_5678, 1'b1, 4'h0, 3'd0, 32'h5234_5678},
    {32'h3FFF_FFFF, 1'b1, 4'h0, 3'd0, 32'h7FFF_FFFF},
    {32'h4000_0000, 1'b0, 4'hF, 3'd0, 32'h4000_0000},
    {32'hE800_0000, 1'b1, 4'h2, 3'd1, 32'hE800_0000},
    {32'hE8FF_FFFF, 1'b1, 4'h2, 3'd1, 32'hE8FF_FFFF},
    {32'hE900_0000, 1'b0, 4'hF, 3'd0, 32'hE900_0000},
    {32'h2345_0000, 1'b1, 4'h0, 3'd0, 32'h6345_0000},
    {32'h5000_ABCD, 1'b1, 4'h5, 3'd3, 32'h0001_ABCD},
    {32'h5001_0000, 1'b0, 4'hF, 3'd0, 32'h5001_0000},
    {32'h6000_0010, 1'b0, 4'hF, 3'd0, 32'h6000_0010},
    {32'h4FFF_FFFF, 1'b0, 4'hF, 3'd0, 32'h4FFF_FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); rv = 1'b1; rw = 1'b1; ra = a; rwd = d;
    @(negedge clk); rv = 1'b0; rw = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); rv = 1'b1; rw = 1'b0; ra = a;
    @(negedge clk); rv = 1'b0;
    chk({req, " rvalid"}, 32'(rrv), 32'd1);
    chk(req, rrd, exp);
  endtask

  task automatic dec(input string req, input logic [31:0] a, input logic h,
                     input logic [3:0] t, input logic [2:0] w, input logic [31:0] x);
    addr = a; #1;
    chk({req, " hit"}, 32'(hit), 32'(h));
    chk({req, " tgt"}, 32'(tgt), 32'(t));
    chk({req, " win"}, 32'(win), 32'(w));
    chk({req, " xaddr"}, xaddr, x);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    dec("R1 reset", 32'hE800_0000, 1'b0, 4'hF, 3'd0, 32'hE800_0000);
    chk("R11 ready", 32'(rrdy), 32'd1);
    rd_chk("R1 ctrl0", 8'h00, 32'h0);
    rd_chk("R1 size2", 8'h24, 32'h0);
    rd_chk("R1 remap4", 8'h4C, 32'h0);

    // configuration: size, base, remap, then ctrl
    wr(8'h04, 32'h0000_3FFF); wr(8'h08, 32'h0000_0000); wr(8'h0C, 32'h4000_0000); wr(8'h00, 32'h01);
    wr(8'h14, 32'h0000_00FF); wr(8'h18, 32'h0000_E800); wr(8'h1C, 32'hE800_0000); wr(8'h10, 32'h21);
    wr(8'h24, 32'h0000_0FFF); wr(8'h28, 32'h0000_2000); wr(8'h2C, 32'hA000_0000); wr(8'h20, 32'h01);
    wr(8'h34, 32'h0000_0000); wr(8'h38, 32'h0000_5000); wr(8'h3C, 32'h0001_0000); wr(8'h30, 32'h51);
    wr(8'h44, 32'h0000_0005); wr(8'h48, 32'h0000_6000); wr(8'h40, 32'h21);

    // R5 R6 R7 R8 R9 R10 vector walk
    for (int i = 0; i < NV; i++)
      dec($sformatf("vec%0d R5 R6 R7 R8 R9 R10", i), VEC[i][71:40], VEC[i][39],
          VEC[i][38:35], VEC[i][34:32], VEC[i][31:0]);

    // R5 base bits under the mask are ignored
    wr(8'h18, 32'h0000_E8AB);
    dec("R5 masked base", 32'hE800_0000, 1'b1, 4'h2, 3'd1, 32'hE800_0000);

    // R4 R11 disable window 0, decode in the very next cycle
    wr(8'h00, 32'h0000_0000);
    dec("R11 R7 w2 exposed", 32'h2345_0000, 1'b1, 4'h0, 3'd2, 32'hA345_0000);
    dec("R4 disabled", 32'h1234_5678, 1'b0, 4'hF, 3'd0, 32'h1234_5678);

    // R2 readback of field bits only
    wr(8'h40, 32'hFFFF_FF21);
    rd_chk("R2 ctrl4", 8'h40, 32'h0000_0021);
    wr(8'h44, 32'hABCD_0003);
    rd_chk("R2 size4", 8'h44, 32'h0000_0003);
    wr(8'h4C, 32'h1234_5678);
    rd_chk("R2 remap4", 8'h4C, 32'h1234_0000);
    rd_chk("R2 base4", 8'h49, 32'h0000_6000);
    // R10 window 4 now has a legal mask
    dec("R10 fixed mask", 32'h6003_0000, 1'b1, 4'h2, 3'd4, 32'h1237_0000);

    // R3 unused offsets
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd_chk("R3 hole 0x50", 8'h50, 32'h0);
    rd_chk("R3 hole 0xFC", 8'hFC, 32'h0);
    dec("R3 decode intact", 32'h4000_0000, 1'b0, 4'hF, 3'd0, 32'h4000_0000);

    // R1 reset in mid-run clears all windows
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    dec("R1 re-reset", 32'hE800_0000, 1'b0, 4'hF, 3'd0, 32'hE800_0000);
    rd_chk("R1 base1 after reset", 8'h18, 32'h0);

    summary();
    $finish;
  end
endmodule